// File: doc/BRIEF.md
# Byte-Serial Auto-Indexed Block Buffer

This block holds one 128-bit block as sixteen bytes behind a single byte-wide register port. An internal byte pointer steps forward on every read and every write of that port. Sixteen back-to-back accesses therefore fill or drain the whole block without any address bits on the bus. The whole block is also driven out in parallel to a cipher engine, and a 128-bit result from that engine can be written back in one cycle.

Two instances sit beside a cipher core, one holding the key and one holding the data state. The buffer remembers whether a full sixteen-access pass took place since the last run. When a run starts, it reports a partial pass as an error. Asserting the sleep input empties the buffer and makes it deaf to register traffic.

Top module: `byte_block_buffer`

## Requirements
- R1: A write access (`wr_en`=1) stores `wdata` into the byte at the current pointer and advances the pointer by one. Byte k appears on `par_data[127-8k -: 8]`, so byte 0 is the most significant byte.
- R2: `rdata` always shows the byte at the current pointer. A read access (`rd_en`=1) advances the pointer by one and changes no byte. When `wr_en` and `rd_en` are both high, this counts as one access that writes, and `rdata` shows the old byte in that cycle.
- R3: An access made with the pointer at 15 returns the pointer to 0 and sets `seq_done` to 1 on the next cycle.
- R4: A `run_start` pulse returns the pointer to 0 and clears `seq_done`. It also loads `run_err` with the inverse of `seq_done` as it was before the pulse. `run_err` holds that value until the next run.
- R5: A `res_load` pulse overwrites all sixteen bytes from `res_data` in one cycle, with byte 0 taken from `res_data[127:120]`. It also returns the pointer to 0, and it leaves `seq_done` and `run_err` unchanged.
- R6: Priority order is sleep, then `res_load`, then `run_start`, then a register access. Any access that arrives in a cycle with a higher-priority action is ignored and does not advance the pointer.
- R7: While `sleep_en` is 1, every byte, the pointer, `seq_done` and `run_err` are cleared, and register accesses have no effect.
- R8: After reset (`rst_n`=0), all bytes, the pointer, `seq_done` and `run_err` are zero.
- R9: In a cycle with no access, no run, no load and no sleep, the bytes and the pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_en | input | 1 | Sleep state: clears the buffer and blocks access |
| wr_en | input | 1 | Byte write access at the pointer |
| rd_en | input | 1 | Byte read access at the pointer |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte at the current pointer |
| run_start | input | 1 | Cipher run start pulse |
| res_load | input | 1 | Load the engine result into all bytes |
| res_data | input | 128 | Engine result |
| par_data | output | 128 | Whole block, byte 0 in the top byte |
| seq_done | output | 1 | A full 16-access pass occurred since the last run |
| run_err | output | 1 | The last run started after a partial pass |

## Verification
The pointer is not a port, so a pointer that is wrong by even one step shows up on the very next read: `rdata` returns a neighbouring byte. It also shows up one cycle after a write, because the byte lands in the wrong lane of `par_data`. A wrap point that is off moves the rise of `seq_done` earlier or later than the sixteenth access. That error surfaces at the following run as a wrong `run_err`. The scoreboard compares every read byte against its expected value in the cycle of the read. `par_data`, `seq_done` and `run_err` are compared after every run, load, sleep and full pass.

// File: rtl/byte_block_buffer.sv
module byte_block_buffer #(
  parameter int BYTES = 16,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_en,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [BW-1:0]       wdata,
  output logic [BW-1:0]       rdata,
  input  logic                run_start,
  input  logic                res_load,
  input  logic [BYTES*BW-1:0] res_data,
  output logic [BYTES*BW-1:0] par_data,
  output logic                seq_done,
  output logic                run_err
);
  localparam int IW   = $clog2(BYTES);
  localparam int WW   = BYTES * BW;
  localparam logic [IW-1:0] LAST = IW'(BYTES - 1);

  logic [BW-1:0] mem [BYTES];
  logic [IW-1:0] idx;
  logic          access;

  assign access = wr_en | rd_en;
  assign rdata  = mem[idx];

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign par_data[WW-1-g*BW -: BW] = mem[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sleep_en) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
      idx      <= '0;
      seq_done <= 1'b0;
      run_err  <= 1'b0;
    end else if (res_load) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= res_data[WW-1-i*BW -: BW];
      idx <= '0;
    end else if (run_start) begin
      idx      <= '0;
      seq_done <= 1'b0;
      run_err  <= ~seq_done;
    end else if (access) begin
      if (wr_en) mem[idx] <= wdata;
      if (idx == LAST) begin
        idx      <= '0;
        seq_done <= 1'b1;
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end
endmodule

// File: rtl/byte_block_buffer_chk.sv
module byte_block_buffer_chk #(
  parameter int BYTES = 16,
  parameter int BW    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sleep_en,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic                        run_start,
  input logic                        res_load,
  input logic [BYTES*BW-1:0]         res_data,
  input logic [BYTES*BW-1:0]         par_data,
  input logic                        seq_done,
  input logic                        run_err,
  input logic [$clog2(BYTES)-1:0]    idx
);
  localparam int IW = $clog2(BYTES);
  logic plain_acc, quiet;
  assign plain_acc = (wr_en | rd_en) & ~sleep_en & ~res_load & ~run_start;
  assign quiet     = ~wr_en & ~rd_en & ~sleep_en & ~res_load & ~run_start;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    plain_acc |=> idx == IW'($past(idx) + 1));  // R1
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_acc && !wr_en) |=> $stable(par_data));  // R2
  AST_WRAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_acc && idx == IW'(BYTES - 1)) |=> seq_done);  // R3
  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && !res_load && !sleep_en) |=> (idx == '0 && !seq_done && run_err == !$past(seq_done)));  // R4
  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && !sleep_en) |=> (par_data == $past(res_data) && idx == '0 && $stable(seq_done)));  // R5
  AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_en |=> (par_data == '0 && idx == '0 && !seq_done && !run_err));  // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> ($stable(par_data) && $stable(idx) && $stable(seq_done)));  // R9
endmodule

bind byte_block_buffer byte_block_buffer_chk #(.BYTES(BYTES), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .wr_en(wr_en), .rd_en(rd_en),
  .run_start(run_start), .res_load(res_load), .res_data(res_data),
  .par_data(par_data), .seq_done(seq_done), .run_err(run_err), .idx(idx)
);

// File: tb/test_byte_block_buffer.sv
`timescale 1ns/100ps
module test_byte_block_buffer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0, sleep_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic         run_start = 1'b0, res_load = 1'b0;
  logic [7:0]   wdata = '0;
  logic [127:0] res_data = '0;
  logic [7:0]   rdata;
  logic [127:0] par_data;
  logic         seq_done, run_err;

  byte_block_buffer i_byte_block_buffer (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .run_start(run_start), .res_load(res_load),
    .res_data(res_data), .par_data(par_data), .seq_done(seq_done), .run_err(run_err)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] mdl [16];
  int  midx = 0;
  bit  mcomp = 0, merr = 0;
  logic [7:0] expq [$];
  string      tagq [$];

  function automatic logic [127:0] mdl_word();
    logic [127:0] w;
    for (int i = 0; i < 16; i++) w[127-8*i -: 8] = mdl[i];
    return w;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read bytes are compared in the cycle of the read
  always @(negedge clk) begin
    #1;
    if (rst_n && rd_en && !sleep_en && !run_start && !res_load) begin
      if (expq.size() == 0) check("R2 unexpected read", 1, 0);
      else check(tagq.pop_front(), {120'd0, rdata}, {120'd0, expq.pop_front()});
    end
  end

  // one cycle of stimulus, with the model stepped at the edge
  task automatic cyc(bit s, bit w, bit r, logic [7:0] d, bit run, bit ld, logic [127:0] res, string tag);
    @(negedge clk);
    sleep_en = s; wr_en = w; rd_en = r; wdata = d; run_start = run; res_load = ld; res_data = res;
    if (r && !s && !run && !ld) begin expq.push_back(mdl[midx]); tagq.push_back(tag); end
    @(posedge clk);
    if (!rst_n || s) begin
      foreach (mdl[i]) mdl[i] = '0; midx = 0; mcomp = 0; merr = 0;
    end else if (ld) begin
      for (int i = 0; i < 16; i++) mdl[i] = res[127-8*i -: 8]; midx = 0;
    end else if (run) begin
      merr = !mcomp; mcomp = 0; midx = 0;
    end else if (w || r) begin
      if (w) mdl[midx] = d;
      if (midx == 15) begin midx = 0; mcomp = 1; end else midx++;
    end
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,"idle"); endtask
  task automatic wr(logic [7:0] d); cyc(0,1,0,d,0,0,0,"R1"); endtask
  task automatic rd(string tag); cyc(0,0,1,0,0,0,0,tag); endtask

  task automatic state(string tag);
    idle();
    #1;
    check({tag, " par_data"}, par_data, mdl_word());
    check({tag, " seq_done"}, {127'd0, seq_done}, {127'd0, mcomp});
    check({tag, " run_err"},  {127'd0, run_err},  {127'd0, merr});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (mdl[i]) mdl[i] = '0;
    repeat (3) cyc(0,0,0,0,0,0,0,"rst");
    rst_n = 1'b1;
    state("R8 reset");
    for (int i = 0; i < 16; i++) wr(8'h10 + 8'(i * 7));
    state("R1 R3 full write");
    for (int i = 0; i < 16; i++) rd("R2 readback");
    state("R2 R3 after full read");
    cyc(0,0,0,0,1,0,0,"run");
    state("R4 run after full pass");
    for (int i = 0; i < 5; i++) wr(8'hA0 + 8'(i));
    cyc(0,0,0,0,1,0,0,"run");
    state("R4 run after partial pass");
    cyc(0,0,0,0,0,1,128'h0123456789ABCDEF_FEDCBA9876543210,"load");
    state("R5 result load");
    for (int i = 0; i < 4; i++) rd("R5 result bytes from 0");
    cyc(0,1,1,8'h5A,0,0,0,"R2 write+read");
    cyc(0,1,1,8'h6B,1,0,0,"R6 access under run");
    state("R6 run wins");
    cyc(0,1,0,8'h77,1,1,128'hCAFE,"R6 load wins");
    state("R6 load wins");
    rd("R6 byte0 after load");
    for (int i = 0; i < 3; i++) wr(8'hC0 + 8'(i));
    for (int i = 0; i < 12; i++) rd("R2 mixed pass");
    state("R3 mixed pass");
    repeat (3) idle();
    state("R9 hold");
    cyc(1,1,0,8'hEE,0,0,0,"sleep");
    cyc(1,0,1,8'h00,0,0,0,"sleep");
    state("R7 sleep clear");
    rd("R7 byte after sleep");
    for (int i = 0; i < 7; i++) wr(8'h30 + 8'(i));
    @(negedge clk); rst_n = 1'b0;
    cyc(0,0,0,0,0,0,0,"rst");
    @(negedge clk); rst_n = 1'b1;
    state("R8 mid-stream reset");
    rd("R8 pointer at 0 after reset");
    cyc(0,0,0,0,1,0,0,"run");
    state("R4 run with no access");
    repeat (2) idle();
    finished = 1'b1;
    if (expq.size() != 0) check("R2 reads pending", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule